// File: doc/BRIEF.md
# Read-to-Acquire Hardware Lock Bank

A bank of single-bit hardware locks shared by several bus masters. A master takes a lock by reading that lock's register. The read returns the lock's state from before the access, and in the same step it leaves the lock marked taken. A returned 0 therefore means the reader now owns the lock, and a returned 1 means another master already held it. A master gives a lock back by writing zero to the lock's register. Any master may release any lock.

The bank holds 32, 64, 128 or 256 locks. A parameter selects one of four one-hot size codes, and the count is that code times 32. A read-only status word reports the size code so that software can discover how many locks exist.

Each master has its own request port. A port accepts a request on every cycle with no back-pressure. The acknowledge, together with any read data, comes exactly one clock after the request. When several masters read the same free lock in one cycle, a fixed priority decides the winner, and the lowest master index gets the lock.

Top module: `hwlk_bank`

## Requirements
- R1: After reset every lock is free, so the first read of any lock returns 0.
- R2: A read of a free lock returns 0 and leaves that lock taken, so the next read of it returns 1.
- R3: A read of a taken lock returns 1, and the lock stays taken.
- R4: A write of data 0 to a lock register frees that lock, whichever master wrote it.
- R5: A write of any nonzero value to a lock register leaves the lock's state unchanged.
- R6: Lock i is at byte address 0x800 + 4*i for i from 0 to NUM_LOCKS-1. An address that is not a multiple of 4 is not a lock register.
- R7: A read of byte address 0x014 returns the size code in bits 31:24, with all other bits 0. The size code is one of 1, 2, 4 or 8, and the lock count is the size code times 32. With the default size code of 1 the word is 0x01000000.
- R8: A read of the status word or of any unmapped address changes no lock. A read of an unmapped address returns 0.
- R9: When several masters read the same free lock in one cycle, only the lowest-numbered of them reads 0. All the others read 1.
- R10: ack is high exactly one cycle after req, and read data is valid in that cycle. A write acknowledges with read data 0.
- R11: When one master releases a taken lock in the same cycle that another master reads it, the reader gets 1 and the lock ends free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_MASTERS | Request strobe, one per master |
| we | input | NUM_MASTERS | 1 = write, 0 = read, one per master |
| addr | input | NUM_MASTERS*ADDR_W | Byte address, one field per master |
| wdata | input | NUM_MASTERS*32 | Write data, one field per master |
| ack | output | NUM_MASTERS | Acknowledge, one cycle after req |
| rdata | output | NUM_MASTERS*32 | Read data, valid with ack |

## Verification
The assertions check on every cycle that the acknowledge follows its request by one clock, that a read returning 0 leaves the lock taken, that a cycle with no acquiring read and no zero write leaves every lock unchanged, that status and unmapped reads return fixed values, and that simultaneous readers of one lock never both win. Only the bench's scenarios show the full sequences: a lock being acquired, refused, ignored on a nonzero write, released and acquired again; the address boundary at the last lock; a release racing a read; and a lock being freed again by a reset in the middle of a run.

// File: rtl/hwlk_pkg.sv
package hwlk_pkg;
  localparam int unsigned LOCK_BASE   = 32'h800;
  localparam int unsigned STATUS_ADDR = 32'h014;
  localparam int unsigned SIZE_LSB    = 24;

  function automatic int unsigned lock_count(input int unsigned size_code);
    return size_code * 32;
  endfunction

  function automatic logic [31:0] status_word(input int unsigned size_code);
    return {8'(size_code), 24'h0};
  endfunction
endpackage

// File: rtl/hwlk_addr_dec.sv
module hwlk_addr_dec #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_LOCKS = 32,
  localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_lock,
  output logic              is_status,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(hwlk_pkg::LOCK_BASE);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(hwlk_pkg::LOCK_BASE + 4 * NUM_LOCKS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(hwlk_pkg::STATUS_ADDR);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset    = addr - BASE_A;
    is_lock   = (addr >= BASE_A) && (addr < END_A) && (addr[1:0] == 2'b00);
    is_status = (addr == STAT_A);
    idx       = offset[IDX_W+1:2];
  end
endmodule

// File: rtl/hwlk_flag_array.sv
module hwlk_flag_array #(
  parameter int unsigned NUM_MASTERS = 2,
  parameter int unsigned NUM_LOCKS   = 32,
  localparam int unsigned IDX_W      = $clog2(NUM_LOCKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] rd_en,
  input  logic [NUM_MASTERS-1:0] rel_en,
  input  logic [IDX_W-1:0]       idx [NUM_MASTERS],
  output logic [NUM_MASTERS-1:0] rd_old,
  output logic [NUM_LOCKS-1:0]   lock_state
);
  logic [NUM_LOCKS-1:0] acq_mask;
  logic [NUM_LOCKS-1:0] rel_mask;

  // a reader loses if the lock was held or a lower-numbered master reads it now
  always_comb begin
    for (int m = 0; m < NUM_MASTERS; m++) begin
      rd_old[m] = lock_state[idx[m]];
      for (int j = 0; j < NUM_MASTERS; j++) begin
        if (j < m && rd_en[j] && idx[j] == idx[m]) rd_old[m] = 1'b1;
      end
    end
  end

  always_comb begin
    acq_mask = '0;
    rel_mask = '0;
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (rd_en[m] && !lock_state[idx[m]]) acq_mask[idx[m]] = 1'b1;
      if (rel_en[m])                       rel_mask[idx[m]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lock_state <= '0;
    else        lock_state <= (lock_state & ~rel_mask) | acq_mask;
  end
endmodule

// File: rtl/hwlk_bank.sv
module hwlk_bank #(
  parameter int unsigned NUM_MASTERS = 2,
  parameter int unsigned SIZE_CODE   = 1,
  parameter int unsigned ADDR_W      = 12,
  localparam int unsigned NUM_LOCKS  = hwlk_pkg::lock_count(SIZE_CODE),
  localparam int unsigned IDX_W      = $clog2(NUM_LOCKS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_MASTERS-1:0]        req,
  input  logic [NUM_MASTERS-1:0]        we,
  input  logic [NUM_MASTERS*ADDR_W-1:0] addr,
  input  logic [NUM_MASTERS*32-1:0]     wdata,
  output logic [NUM_MASTERS-1:0]        ack,
  output logic [NUM_MASTERS*32-1:0]     rdata
);
  localparam logic [31:0] STATUS_VAL = hwlk_pkg::status_word(SIZE_CODE);

  logic [NUM_MASTERS-1:0] is_lock, is_status, rd_en, rel_en, rd_old;
  logic [IDX_W-1:0]       idx [NUM_MASTERS];
  logic [NUM_LOCKS-1:0]   lock_state;
  logic [31:0]            rdata_d [NUM_MASTERS];

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_port
    hwlk_addr_dec #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS)) dec_i (
      .addr      (addr[m*ADDR_W +: ADDR_W]),
      .is_lock   (is_lock[m]),
      .is_status (is_status[m]),
      .idx       (idx[m])
    );

    assign rd_en[m]  = req[m] && !we[m] && is_lock[m];
    assign rel_en[m] = req[m] &&  we[m] && is_lock[m] && (wdata[m*32 +: 32] == 32'h0);

    always_comb begin
      if (!req[m] || we[m]) rdata_d[m] = 32'h0;
      else if (is_lock[m])  rdata_d[m] = {31'h0, rd_old[m]};
      else if (is_status[m]) rdata_d[m] = STATUS_VAL;
      else                  rdata_d[m] = 32'h0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ack[m]             <= 1'b0;
        rdata[m*32 +: 32]  <= 32'h0;
      end else begin
        ack[m]             <= req[m];
        rdata[m*32 +: 32]  <= rdata_d[m];
      end
    end
  end

  hwlk_flag_array #(.NUM_MASTERS(NUM_MASTERS), .NUM_LOCKS(NUM_LOCKS)) flags_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rel_en     (rel_en),
    .idx        (idx),
    .rd_old     (rd_old),
    .lock_state (lock_state)
  );
endmodule

// File: rtl/hwlk_bank_chk.sv
module hwlk_bank_chk #(
  parameter int unsigned NUM_MASTERS = 2,
  parameter int unsigned SIZE_CODE   = 1,
  parameter int unsigned ADDR_W      = 12,
  localparam int unsigned NUM_LOCKS  = SIZE_CODE * 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_MASTERS-1:0]        req,
  input logic [NUM_MASTERS-1:0]        we,
  input logic [NUM_MASTERS*ADDR_W-1:0] addr,
  input logic [NUM_MASTERS*32-1:0]     wdata,
  input logic [NUM_MASTERS-1:0]        ack,
  input logic [NUM_MASTERS*32-1:0]     rdata,
  input logic [NUM_LOCKS-1:0]          lock_state
);
  localparam int unsigned LO = 32'h800;
  localparam int unsigned HI = 32'h800 + 4 * NUM_LOCKS;

  logic past_ok;
  logic [NUM_MASTERS-1:0] lk_rd, lk_wr0, un_rd, st_rd;
  logic [NUM_MASTERS-1:0] lk_rd_q, un_rd_q, st_rd_q;
  int unsigned            lidx   [NUM_MASTERS];
  int unsigned            lidx_q [NUM_MASTERS];
  logic                   quiet;

  always_comb begin
    quiet = 1'b1;
    for (int m = 0; m < NUM_MASTERS; m++) begin
      automatic int unsigned a = int'(addr[m*ADDR_W +: ADDR_W]);
      automatic logic in_lk = (a >= LO) && (a < HI) && (a % 4 == 0);
      lidx[m]   = in_lk ? (a - LO) / 4 : 0;
      lk_rd[m]  = req[m] && !we[m] && in_lk;
      lk_wr0[m] = req[m] &&  we[m] && in_lk && (wdata[m*32 +: 32] == 32'h0);
      st_rd[m]  = req[m] && !we[m] && (a == 32'h014);
      un_rd[m]  = req[m] && !we[m] && !in_lk && (a != 32'h014);
      if (lk_rd[m] || lk_wr0[m]) quiet = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      lk_rd_q <= '0;
      un_rd_q <= '0;
      st_rd_q <= '0;
      for (int m = 0; m < NUM_MASTERS; m++) lidx_q[m] <= 0;
    end else begin
      past_ok <= 1'b1;
      lk_rd_q <= lk_rd;
      un_rd_q <= un_rd;
      st_rd_q <= st_rd;
      for (int m = 0; m < NUM_MASTERS; m++) lidx_q[m] <= lidx[m];
    end
  end

  p_quiet_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(quiet)) |-> (lock_state == $past(lock_state)));

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_m
    p_ack_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (ack[m] == $past(req[m])));

    p_win_marks_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && lk_rd_q[m] && rdata[m*32 +: 32] == 32'h0) |-> lock_state[lidx_q[m]]);

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && un_rd_q[m]) |-> (rdata[m*32 +: 32] == 32'h0));

    p_status_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && st_rd_q[m]) |-> (rdata[m*32 +: 32] == {8'(SIZE_CODE), 24'h0}));

    if (m > 0) begin : g_pair
      p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && lk_rd_q[0] && lk_rd_q[m] && lidx_q[0] == lidx_q[m])
          |-> (rdata[m*32 +: 32] == 32'h1));
    end
  end
endmodule

bind hwlk_bank hwlk_bank_chk #(
  .NUM_MASTERS(NUM_MASTERS), .SIZE_CODE(SIZE_CODE), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
  .ack(ack), .rdata(rdata), .lock_state(lock_state)
);

// File: tb/hwlk_bank_tb_top.sv
module hwlk_bank_tb_top;
  localparam int NM = 2;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NM-1:0]    req = '0, we = '0, ack;
  logic [NM*AW-1:0] addr = '0;
  logic [NM*32-1:0] wdata = '0, rdata;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  hwlk_bank #(.NUM_MASTERS(NM), .SIZE_CODE(1), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .ack(ack), .rdata(rdata)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1'b0, 12'h800, 32'h0, 32'h0},        // R1 R2 first read of lock 0 wins
    '{1'b0, 12'h800, 32'h0, 32'h1},        // R3 now taken
    '{1'b1, 12'h800, 32'h5, 32'h0},        // R5 nonzero write, acked with 0
    '{1'b0, 12'h800, 32'h0, 32'h1},        // R5 still taken
    '{1'b1, 12'h800, 32'h0, 32'h0},        // R4 release
    '{1'b0, 12'h800, 32'h0, 32'h0},        // R4 free again, retaken
    '{1'b0, 12'h87C, 32'h0, 32'h0},        // R6 last lock
    '{1'b0, 12'h87C, 32'h0, 32'h1},        // R6 last lock taken
    '{1'b0, 12'h880, 32'h0, 32'h0},        // R8 past the last lock
    '{1'b0, 12'h880, 32'h0, 32'h0},        // R8 no side effect
    '{1'b0, 12'h802, 32'h0, 32'h0},        // R6 unaligned is unmapped
    '{1'b0, 12'h014, 32'h0, 32'h01000000}, // R7 status word
    '{1'b0, 12'h804, 32'h0, 32'h0},        // R6 R8 lock 1 untouched so far
    '{1'b0, 12'h010, 32'h0, 32'h0}         // R8 unmapped
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int m, input logic w, input logic [11:0] a, input logic [31:0] d);
    req[m] = 1'b1;
    we[m] = w;
    addr[m*AW +: AW] = a;
    wdata[m*32 +: 32] = d;
  endtask

  task automatic idle();
    req = '0;
    we = '0;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ack low when idle", {31'h0, ack[0]}, 32'h0);

    foreach (VECS[k]) begin
      drive(0, VECS[k].wr, VECS[k].a, VECS[k].d);
      @(negedge clk);
      idle();
      check($sformatf("R10 ack vec %0d", k), {31'h0, ack[0]}, 32'h1);
      check($sformatf("vec %0d rdata", k), rdata[31:0], VECS[k].exp);
    end
    @(negedge clk);
    check("R10 ack drops", {31'h0, ack[0]}, 32'h0);

    // R9 both masters read free lock 5 together
    drive(0, 1'b0, 12'h814, 32'h0);
    drive(1, 1'b0, 12'h814, 32'h0);
    @(negedge clk);
    idle();
    check("R9 master0 wins", rdata[31:0], 32'h0);
    check("R9 master1 loses", rdata[63:32], 32'h1);
    check("R10 ack master1", {31'h0, ack[1]}, 32'h1);

    // R11 master0 releases lock 5 while master1 reads it
    drive(0, 1'b1, 12'h814, 32'h0);
    drive(1, 1'b0, 12'h814, 32'h0);
    @(negedge clk);
    idle();
    check("R11 racing reader sees taken", rdata[63:32], 32'h1);
    drive(1, 1'b0, 12'h814, 32'h0);
    @(negedge clk);
    idle();
    check("R11 lock ended free", rdata[63:32], 32'h0);

    // R4 master1 holds lock 5, master0 releases it
    drive(0, 1'b1, 12'h814, 32'h0);
    @(negedge clk);
    idle();
    drive(0, 1'b0, 12'h814, 32'h0);
    @(negedge clk);
    idle();
    check("R4 cross-master release", rdata[31:0], 32'h0);

    // R8 status read does not touch lock 2
    drive(1, 1'b0, 12'h014, 32'h0);
    @(negedge clk);
    idle();
    check("R7 status via master1", rdata[63:32], 32'h01000000);
    drive(1, 1'b0, 12'h808, 32'h0);
    @(negedge clk);
    idle();
    check("R8 lock 2 still free", rdata[63:32], 32'h0);

    // R1 reset frees held locks
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 ack cleared by reset", {30'h0, ack}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(0, 1'b0, 12'h800, 32'h0);
    @(negedge clk);
    idle();
    check("R1 lock 0 free after reset", rdata[31:0], 32'h0);
    drive(0, 1'b0, 12'h87C, 32'h0);
    @(negedge clk);
    idle();
    check("R1 lock 31 free after reset", rdata[31:0], 32'h0);

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule